// File: doc/BRIEF.md
# Vertical Sync Mode Recognition State Machine

This block decides, once per television field, whether the vertical countdown divider runs locked to the received signal or runs free. In locked (standard) mode the divider counts a fixed number of lines and only checks the incoming integrated vertical sync for coincidence. In free (non-standard) mode the divider is restarted by each incoming vertical pulse. The block sees a field boundary strobe, a coincidence flag for the field that ends on that strobe, and two pulse streams with their windows, all supplied by the countdown counter. From these it counts equalizing pulses inside the vertical drive window and noise pulses inside the active scan window.

Entry into locked mode needs a run of qualifying fields. Once locked, the block rides through a bounded number of bad fields before it gives up. A burst of noise on the vertical sync input while free arms a fast path that locks on the next qualifying field without waiting for the run. A forcing input holds the block free whatever the sync looks like. The block drives the mode, a level that asks the counter to restart on each incoming pulse, and a one-cycle strobe when the mode flips.

Top module: `vsync_mode_recog`

## Requirements
- R1: After reset `std_mode` is 0, `resync_req` is 1 and `mode_change` is 0.
- R2: An equalizing pulse counts only when `eq_pulse` and `eq_window` are both 1 in a cycle where `field_end` is 0; a field qualifies when `coinc` is 1 at its `field_end` and at least 9 equalizing pulses were counted in it. Counts clear at every `field_end`.
- R3: While free, the 7th consecutive qualifying field sets `std_mode` to 1 at its `field_end`; any non-qualifying field restarts the run, and a field without coincidence never locks.
- R4: While locked, `std_mode` stays 1 through 6 consecutive non-qualifying fields and drops to 0 at the 7th; a qualifying field restarts that miss run, and a qualifying field never unlocks.
- R5: A noise pulse counts only when `noise_pulse` and `scan_window` are both 1 (and `field_end` is 0); a free-mode field with 2 or more counted noise pulses locks at once if it qualifies, or else arms a fast path that locks at the next qualifying field. One noise pulse has no effect.
- R6: After a fast lock the block holds through 6 non-qualifying fields and drops at the 7th, as in R4.
- R7: When `force_async` is 1 at a `field_end`, `std_mode` is 0 after it, and the lock run and any armed fast path are cleared.
- R8: The equalizing count saturates at 15 and the noise count at 3 instead of wrapping.
- R9: `std_mode` changes only on the clock edge that registers a `field_end`; `mode_change` is 1 for exactly the one cycle after an edge where `std_mode` toggled and 0 otherwise.
- R10: `resync_req` is the inverse of `std_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_end | input | 1 | One-cycle strobe closing the current field |
| coinc | input | 1 | Internal vertical count coincided with external sync this field (sampled at `field_end`) |
| eq_window | input | 1 | Vertical drive window from the counter |
| eq_pulse | input | 1 | Equalizing pulse strobe |
| scan_window | input | 1 | Active scan window from the counter |
| noise_pulse | input | 1 | Pulse strobe seen on the vertical sync input |
| force_async | input | 1 | Hold in free mode (sampled at `field_end`) |
| std_mode | output | 1 | 1 = locked standard mode, 0 = free mode |
| resync_req | output | 1 | Ask the counter to restart on each incoming vertical pulse |
| mode_change | output | 1 | One-cycle strobe after the mode toggles |

## Verification
Runs of fully qualifying fields, fields with eight equalizing pulses, fields without coincidence and broken runs separate the seven-field entry count and the seven-field exit count from off-by-one variants and from a run that fails to restart. Noise bursts of one, two and four pulses, with and without coincidence in the same field, tell the fast path apart from the normal run and expose a noise counter that wraps. Pulses driven just outside their windows and twenty-pulse fields show that gating and saturation are real, and forcing applied while locked, while a run is in progress and while a fast path is armed shows that it wins and clears the pending state.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_STD  = 1'b1
    } vmr_mode_e;

endpackage

// File: rtl/vmr_win_counter.sv
module vmr_win_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         win,
    input  logic         pulse,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (win && pulse && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R8: a full counter stays full when another pulse arrives
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && win && pulse && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R2: the field boundary empties the counter
    assert_clear_on_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/vmr_mode_core.sv
module vmr_mode_core
    import vmr_pkg::*;
#(
    parameter int LOCK_FIELDS = 7,
    parameter int MISS_LIMIT  = 7,
    parameter int EQ_MIN      = 9,
    parameter int NOISE_MIN   = 2,
    parameter int EQ_W        = 4,
    parameter int NOISE_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               field_end,
    input  logic               coinc,
    input  logic               force_async,
    input  logic [EQ_W-1:0]    eq_cnt,
    input  logic [NOISE_W-1:0] noise_cnt,
    output logic               std_mode,
    output logic               mode_change
);
    localparam int RUN_W  = $clog2(LOCK_FIELDS + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [RUN_W-1:0]   RUN_LAST  = RUN_W'(LOCK_FIELDS - 1);
    localparam logic [MISS_W-1:0]  MISS_LAST = MISS_W'(MISS_LIMIT - 1);
    localparam logic [EQ_W-1:0]    EQ_THR    = EQ_W'(EQ_MIN);
    localparam logic [NOISE_W-1:0] NOISE_THR = NOISE_W'(NOISE_MIN);

    typedef struct packed {
        vmr_mode_e         mode;
        logic [RUN_W-1:0]  run;
        logic [MISS_W-1:0] miss;
        logic              fast;
        logic              chg;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        good;
    logic        noisy;

    always_comb begin
        good  = coinc && (eq_cnt >= EQ_THR);
        noisy = (noise_cnt >= NOISE_THR);
        s_d     = s_q;
        s_d.chg = 1'b0;
        if (field_end) begin
            if (force_async) begin
                s_d.mode = MODE_FREE;
                s_d.run  = '0;
                s_d.miss = '0;
                s_d.fast = 1'b0;
            end else if (s_q.mode == MODE_FREE) begin
                if (good && (s_q.fast || noisy)) begin
                    s_d.mode = MODE_STD;
                    s_d.run  = '0;
                    s_d.miss = '0;
                    s_d.fast = 1'b0;
                end else if (good) begin
                    if (s_q.run == RUN_LAST) begin
                        s_d.mode = MODE_STD;
                        s_d.run  = '0;
                        s_d.miss = '0;
                    end else begin
                        s_d.run = s_q.run + 1'b1;
                    end
                end else begin
                    s_d.run = '0;
                    if (noisy) s_d.fast = 1'b1;
                end
            end else begin
                if (good) begin
                    s_d.miss = '0;
                end else if (s_q.miss == MISS_LAST) begin
                    s_d.mode = MODE_FREE;
                    s_d.miss = '0;
                    s_d.run  = '0;
                    s_d.fast = 1'b0;
                end else begin
                    s_d.miss = s_q.miss + 1'b1;
                end
            end
            s_d.chg = (s_d.mode != s_q.mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_FREE, run: '0, miss: '0, fast: 1'b0, chg: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign std_mode    = (s_q.mode == MODE_STD);
    assign mode_change = s_q.chg;

    // R9: the mode moves only on a field boundary
    assert_mode_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> $stable(s_q.mode));

    // R9: the toggle strobe never lasts two cycles
    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !mode_change);

    // R7: forcing wins at the boundary
    assert_force_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && force_async) |=> (s_q.mode == MODE_FREE));

    // R3: a field without coincidence cannot lock a free block
    assert_no_lock_without_coinc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && !coinc && s_q.mode == MODE_FREE) |=> (s_q.mode == MODE_FREE));

    // R4: a qualifying unforced field keeps the lock
    assert_good_keeps_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && !force_async && coinc && eq_cnt >= EQ_THR && s_q.mode == MODE_STD)
        |=> (s_q.mode == MODE_STD));

endmodule

// File: rtl/vsync_mode_recog.sv
module vsync_mode_recog #(
    parameter int LOCK_FIELDS = 7,
    parameter int MISS_LIMIT  = 7,
    parameter int EQ_MIN      = 9,
    parameter int NOISE_MIN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_end,
    input  logic coinc,
    input  logic eq_window,
    input  logic eq_pulse,
    input  logic scan_window,
    input  logic noise_pulse,
    input  logic force_async,
    output logic std_mode,
    output logic resync_req,
    output logic mode_change
);
    localparam int EQ_W    = $clog2(EQ_MIN + 1);
    localparam int NOISE_W = $clog2(NOISE_MIN + 1);

    logic [EQ_W-1:0]    eq_cnt;
    logic [NOISE_W-1:0] noise_cnt;

    vmr_win_counter #(.W(EQ_W)) u_eq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (eq_window),
        .pulse (eq_pulse),
        .clr   (field_end),
        .cnt   (eq_cnt)
    );

    vmr_win_counter #(.W(NOISE_W)) u_noise_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (scan_window),
        .pulse (noise_pulse),
        .clr   (field_end),
        .cnt   (noise_cnt)
    );

    vmr_mode_core #(
        .LOCK_FIELDS (LOCK_FIELDS),
        .MISS_LIMIT  (MISS_LIMIT),
        .EQ_MIN      (EQ_MIN),
        .NOISE_MIN   (NOISE_MIN),
        .EQ_W        (EQ_W),
        .NOISE_W     (NOISE_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_end   (field_end),
        .coinc       (coinc),
        .force_async (force_async),
        .eq_cnt      (eq_cnt),
        .noise_cnt   (noise_cnt),
        .std_mode    (std_mode),
        .mode_change (mode_change)
    );

    assign resync_req = !std_mode;

    // R10: restart request and lock are never asserted together
    assert_resync_vs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req != std_mode));

endmodule

// File: tb/vsync_mode_recog_bench.sv
module vsync_mode_recog_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_end = 1'b0, coinc = 1'b0, eq_window = 1'b0, eq_pulse = 1'b0;
    logic scan_window = 1'b0, noise_pulse = 1'b0, force_async = 1'b0;
    logic std_mode, resync_req, mode_change;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    vsync_mode_recog u_vsync_mode_recog (
        .clk(clk), .rst_n(rst_n), .field_end(field_end), .coinc(coinc),
        .eq_window(eq_window), .eq_pulse(eq_pulse), .scan_window(scan_window),
        .noise_pulse(noise_pulse), .force_async(force_async),
        .std_mode(std_mode), .resync_req(resync_req), .mode_change(mode_change)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One field: pulses in and out of windows, then the boundary strobe.
    // Returns at the negedge after the boundary edge, where outputs are settled.
    task automatic field(input int neq, input int nnoise, input bit co, input bit frc,
                         input int neq_out = 0, input int nnoise_out = 0);
        for (int i = 0; i < 44; i++) begin
            @(negedge clk);
            eq_window = 1'b1;
            eq_pulse  = ((i % 2) == 0) && ((i / 2) < neq);
        end
        for (int i = 0; i < neq_out + 1; i++) begin
            @(negedge clk);
            eq_window = 1'b0;
            eq_pulse  = (i < neq_out);
        end
        eq_pulse = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            scan_window = 1'b1;
            noise_pulse = ((i % 2) == 0) && ((i / 2) < nnoise);
        end
        for (int i = 0; i < nnoise_out + 1; i++) begin
            @(negedge clk);
            scan_window = 1'b0;
            noise_pulse = (i < nnoise_out);
        end
        @(negedge clk);
        noise_pulse = 1'b0;
        field_end   = 1'b1;
        coinc       = co;
        force_async = frc;
        @(negedge clk);
        field_end   = 1'b0;
        coinc       = 1'b0;
        force_async = 1'b0;
    endtask

    task automatic good_fields(input int n);
        for (int i = 0; i < n; i++) field(9, 0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 std_mode after reset", std_mode, 1'b0);
        chk("R1 resync_req after reset", resync_req, 1'b1);
        chk("R1 mode_change after reset", mode_change, 1'b0);
    endtask

    task automatic t_lock_seven();
        do_reset();
        good_fields(6);
        chk("R3 no lock after six fields", std_mode, 1'b0);
        chk("R9 no strobe without toggle", mode_change, 1'b0);
        good_fields(1);
        chk("R3 lock at seventh field", std_mode, 1'b1);
        chk("R9 strobe on lock", mode_change, 1'b1);
        chk("R10 resync drops on lock", resync_req, 1'b0);
        @(negedge clk);
        chk("R9 strobe lasts one cycle", mode_change, 1'b0);
        chk("R9 mode steady between boundaries", std_mode, 1'b1);
    endtask

    task automatic t_run_restart();
        do_reset();
        good_fields(6);
        field(9, 0, 1'b0, 1'b0);
        good_fields(6);
        chk("R3 broken run restarts", std_mode, 1'b0);
        good_fields(1);
        chk("R3 lock after fresh run of seven", std_mode, 1'b1);
    endtask

    task automatic t_eq_threshold();
        do_reset();
        for (int i = 0; i < 8; i++) field(8, 0, 1'b1, 1'b0);
        chk("R2 eight pulses never qualify", std_mode, 1'b0);
        do_reset();
        for (int i = 0; i < 8; i++) field(5, 0, 1'b1, 1'b0, 6);
        chk("R2 pulses outside window ignored", std_mode, 1'b0);
    endtask

    task automatic t_hold_six();
        do_reset();
        good_fields(7);
        for (int i = 0; i < 6; i++) field(8, 0, 1'b1, 1'b0);
        chk("R4 lock held through six short fields", std_mode, 1'b1);
        field(8, 0, 1'b1, 1'b0);
        chk("R4 drop at seventh short field", std_mode, 1'b0);
        chk("R9 strobe on drop", mode_change, 1'b1);
        chk("R10 resync back on drop", resync_req, 1'b1);
        do_reset();
        good_fields(7);
        for (int i = 0; i < 5; i++) field(9, 0, 1'b0, 1'b0);
        good_fields(1);
        for (int i = 0; i < 6; i++) field(9, 0, 1'b0, 1'b0);
        chk("R4 good field restarts miss run", std_mode, 1'b1);
        field(9, 0, 1'b0, 1'b0);
        chk("R4 drop after seven misses", std_mode, 1'b0);
    endtask

    task automatic t_fast();
        do_reset();
        field(0, 2, 1'b0, 1'b0);
        chk("R5 noisy bad field does not lock", std_mode, 1'b0);
        good_fields(1);
        chk("R5 fast lock at next qualifying field", std_mode, 1'b1);
        for (int i = 0; i < 6; i++) field(0, 0, 1'b0, 1'b0);
        chk("R6 fast lock held six fields", std_mode, 1'b1);
        field(0, 0, 1'b0, 1'b0);
        chk("R6 fast lock drops at seventh", std_mode, 1'b0);
        do_reset();
        field(9, 2, 1'b1, 1'b0);
        chk("R5 noisy qualifying field locks at once", std_mode, 1'b1);
        do_reset();
        field(0, 1, 1'b0, 1'b0);
        good_fields(1);
        chk("R5 single noise pulse no effect", std_mode, 1'b0);
        do_reset();
        field(0, 1, 1'b0, 1'b0, 0, 4);
        good_fields(1);
        chk("R5 noise outside scan window ignored", std_mode, 1'b0);
    endtask

    task automatic t_force();
        do_reset();
        for (int i = 0; i < 8; i++) field(9, 0, 1'b1, 1'b1);
        chk("R7 forced fields never lock", std_mode, 1'b0);
        good_fields(7);
        chk("R7 lock after forcing released", std_mode, 1'b1);
        field(9, 0, 1'b1, 1'b1);
        chk("R7 forcing unlocks", std_mode, 1'b0);
        do_reset();
        good_fields(6);
        field(9, 0, 1'b1, 1'b1);
        good_fields(1);
        chk("R7 forcing clears run", std_mode, 1'b0);
        do_reset();
        field(0, 2, 1'b0, 1'b0);
        field(9, 0, 1'b1, 1'b1);
        good_fields(1);
        chk("R7 forcing clears fast path", std_mode, 1'b0);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 7; i++) field(20, 0, 1'b1, 1'b0);
        chk("R8 equalizing count saturates", std_mode, 1'b1);
        do_reset();
        field(0, 4, 1'b0, 1'b0);
        good_fields(1);
        chk("R8 noise count saturates", std_mode, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_lock_seven();
        t_run_restart();
        t_eq_threshold();
        t_hold_six();
        t_fast();
        t_force();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule